// File: doc/BRIEF.md
# Evolution Stall Detection Trigger

This block watches an evolutionary circuit search one generation at a time and decides when the search should stop and pass its best candidate to a repair stage. Each time a generation finishes, the search engine pulses a strobe together with that generation's best fitness. The monitor keeps a count of back-to-back generations whose best fitness did not change, and it raises a sticky repair-start flag for one of two reasons. The first is that the best fitness has come within a fixed percentage (95 by default) of the maximum achievable fitness. The second is that the count of unchanged generations has reached a programmable limit.

The near-complete test is made first on every strobe. If it passes, the trigger is set and the counter is left as it was. The counter is cleared by any change in best fitness, whether up or down. The first strobe after reset or restart has nothing to compare against, so it never counts as a repeat. Once the flag is raised, later strobes are ignored. A restart pulse then clears the flag, the counter and the stored fitness so that a fresh search can begin. The stall limit is an input and is normally set to 300.

Top module: `stall_trigger`

## Requirements
- R1: After reset, repair_o is 0 and stall_cnt_o is 0.
- R2: On a strobe with best_fit_i*100 >= max_fit_i*NEAR_PCT (NEAR_PCT = 95), repair_o is 1 after that edge and stall_cnt_o is unchanged. One unit below the boundary does not trigger.
- R3: On a strobe below the threshold whose best_fit_i equals the previous accepted strobe's value, stall_cnt_o increments by one.
- R4: On a strobe below the threshold whose best_fit_i differs from the previous value, higher or lower, stall_cnt_o becomes 0.
- R5: The first strobe after reset or restart never counts as a repeat; stall_cnt_o becomes 0.
- R6: When a below-threshold strobe brings the updated count to a value >= stall_limit_i, repair_o is 1 after that same edge. With stall_limit_i = 0, the first below-threshold strobe triggers.
- R7: While repair_o is 1, strobes are ignored: repair_o stays 1 and stall_cnt_o holds.
- R8: restart_i clears repair_o, stall_cnt_o and the stored previous fitness after the next edge, and it takes priority over a strobe in the same cycle.
- R9: stall_cnt_o saturates at 2^CNT_W-1 and does not wrap.
- R10: Cycles without a strobe change neither output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| restart_i | input | 1 | Synchronous clear of trigger, counter and stored fitness |
| gen_valid_i | input | 1 | One-cycle strobe at the end of each generation |
| best_fit_i | input | FIT_W | Best fitness of the generation |
| max_fit_i | input | FIT_W | Maximum achievable fitness |
| stall_limit_i | input | LIM_W | Number of unchanged generations that triggers repair |
| repair_o | output | 1 | Sticky repair-start flag |
| stall_cnt_o | output | CNT_W | Current count of unchanged generations |

## Verification
Both outputs are registered. A strobe or restart driven before a rising edge therefore shows its effect on repair_o and stall_cnt_o right after that edge, with no further delay. The bench drives every input on the falling edge, lets one rising edge pass, and samples on the next falling edge. It then compares against a bench model that it advances once per edge. Idle cycles are checked the same way, one edge after the last strobe. A second instance with a 3-bit counter and a limit of 15 makes saturation visible without a trigger.

// File: rtl/stall_trig_pkg.sv
package stall_trig_pkg;
  localparam int unsigned PctScale = 100;
  localparam int unsigned PctW     = $clog2(PctScale + 1);
endpackage

// File: rtl/near_check.sv
module near_check
  import stall_trig_pkg::*;
#(
  parameter int unsigned FIT_W    = 16,
  parameter int unsigned NEAR_PCT = 95
) (
  input  logic [FIT_W-1:0] best_i,
  input  logic [FIT_W-1:0] max_i,
  output logic             near_o
);
  localparam int unsigned ProdW = FIT_W + PctW;

  logic [ProdW-1:0] lhs, rhs;

  // widened so neither product can overflow
  assign lhs    = ProdW'(best_i) * ProdW'(PctScale);
  assign rhs    = ProdW'(max_i) * ProdW'(NEAR_PCT);
  assign near_o = (lhs >= rhs);
endmodule

// File: rtl/stall_counter.sv
module stall_counter #(
  parameter int unsigned FIT_W = 16,
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic [FIT_W-1:0] fit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o
);
  localparam logic [CNT_W-1:0] CntMax = '1;

  logic [FIT_W-1:0] prev_q;
  logic             have_prev_q;
  logic [CNT_W-1:0] cnt_q;
  logic             same;

  assign same      = have_prev_q && (fit_i == prev_q);
  assign cnt_nxt_o = !same ? '0 : (cnt_q == CntMax) ? cnt_q : cnt_q + 1'b1;
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      prev_q      <= '0;
      have_prev_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q       <= '0;
      prev_q      <= '0;
      have_prev_q <= 1'b0;
    end else if (step_i) begin
      cnt_q       <= cnt_nxt_o;
      prev_q      <= fit_i;
      have_prev_q <= 1'b1;
    end
  end

  // R3
  repeat_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clr_i && have_prev_q && fit_i == prev_q && cnt_q != CntMax)
      |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
  // R4
  change_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clr_i && have_prev_q && fit_i != prev_q) |=> (cnt_q == '0));
  // R5
  first_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clr_i && !have_prev_q) |=> (cnt_q == '0));
  // R9
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CntMax && step_i && !clr_i && fit_i == prev_q) |=> (cnt_q == CntMax));
endmodule

// File: rtl/stall_trigger.sv
module stall_trigger
  import stall_trig_pkg::*;
#(
  parameter int unsigned FIT_W    = 16,
  parameter int unsigned CNT_W    = 9,
  parameter int unsigned LIM_W    = CNT_W,
  parameter int unsigned NEAR_PCT = 95
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             gen_valid_i,
  input  logic [FIT_W-1:0] best_fit_i,
  input  logic [FIT_W-1:0] max_fit_i,
  input  logic [LIM_W-1:0] stall_limit_i,
  output logic             repair_o,
  output logic [CNT_W-1:0] stall_cnt_o
);
  localparam int unsigned CmpW = (LIM_W > CNT_W) ? LIM_W : CNT_W;

  logic             trig_q;
  logic             near;
  logic             armed;
  logic             step;
  logic [CNT_W-1:0] cnt_nxt;
  logic             stalled;

  near_check #(
    .FIT_W   (FIT_W),
    .NEAR_PCT(NEAR_PCT)
  ) i_near_check (
    .best_i(best_fit_i),
    .max_i (max_fit_i),
    .near_o(near)
  );

  // threshold test wins: a near-complete strobe leaves the counter alone
  assign armed = gen_valid_i && !trig_q && !restart_i;
  assign step  = armed && !near;

  stall_counter #(
    .FIT_W(FIT_W),
    .CNT_W(CNT_W)
  ) i_stall_counter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (restart_i),
    .step_i   (step),
    .fit_i    (best_fit_i),
    .cnt_o    (stall_cnt_o),
    .cnt_nxt_o(cnt_nxt)
  );

  assign stalled = (CmpW'(cnt_nxt) >= CmpW'(stall_limit_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        trig_q <= 1'b0;
    else if (restart_i)                 trig_q <= 1'b0;
    else if (armed && (near || stalled)) trig_q <= 1'b1;
  end

  assign repair_o = trig_q;

  // R2
  near_trig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gen_valid_i && !restart_i && !repair_o && near) |=> (repair_o && $stable(stall_cnt_o)));
  // R6
  stall_trig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gen_valid_i && !restart_i && !repair_o && CmpW'(cnt_nxt) >= CmpW'(stall_limit_i))
      |=> repair_o);
  // R7
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (repair_o && !restart_i) |=> (repair_o && $stable(stall_cnt_o)));
  // R8
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (!repair_o && stall_cnt_o == '0));
  // R10
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gen_valid_i && !restart_i) |=> ($stable(repair_o) && $stable(stall_cnt_o)));
endmodule

// File: tb/test_stall_trigger.sv
module test_stall_trigger;
  localparam int FIT_W = 16;
  localparam int CNT_W = 9;
  localparam int MAXC  = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             restart = 1'b0;
  logic             valid = 1'b0;
  logic [FIT_W-1:0] best = '0;
  logic [FIT_W-1:0] maxf = 16'd1000;
  logic [CNT_W-1:0] limit = 9'd3;
  logic             repair;
  logic [CNT_W-1:0] cnt;

  logic             s_valid = 1'b0;
  logic [FIT_W-1:0] s_best = '0;
  logic             s_repair;
  logic [2:0]       s_cnt;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 0;

  int  m_cnt = 0;
  bit  m_rep = 0;
  bit  m_hp = 0;
  int  m_prev = 0;

  always #4 clk = ~clk;

  stall_trigger #(.FIT_W(FIT_W), .CNT_W(CNT_W)) i_stall_trigger (
    .clk_i(clk), .rst_ni(rst_n), .restart_i(restart), .gen_valid_i(valid),
    .best_fit_i(best), .max_fit_i(maxf), .stall_limit_i(limit),
    .repair_o(repair), .stall_cnt_o(cnt));

  stall_trigger #(.FIT_W(FIT_W), .CNT_W(3), .LIM_W(4)) i_stall_trigger_sat (
    .clk_i(clk), .rst_ni(rst_n), .restart_i(1'b0), .gen_valid_i(s_valid),
    .best_fit_i(s_best), .max_fit_i(16'd1000), .stall_limit_i(4'd15),
    .repair_o(s_repair), .stall_cnt_o(s_cnt));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit is_near(input int b, input int m);
    return longint'(b) * 100 >= longint'(m) * 95;
  endfunction

  task automatic model(input bit rs, input bit v, input int b);
    if (rs) begin
      m_cnt = 0; m_rep = 0; m_hp = 0; m_prev = 0;
    end else if (v && !m_rep) begin
      if (is_near(b, int'(maxf))) m_rep = 1;
      else begin
        m_cnt = (m_hp && b == m_prev) ? ((m_cnt < MAXC) ? m_cnt + 1 : MAXC) : 0;
        m_prev = b; m_hp = 1;
        if (m_cnt >= int'(limit)) m_rep = 1;
      end
    end
  endtask

  task automatic cyc(input bit rs, input bit v, input int b, input string req);
    @(negedge clk);
    restart = rs; valid = v; best = FIT_W'(b);
    @(posedge clk);
    model(rs, v, b);
    @(negedge clk);
    restart = 0; valid = 0;
    check(repair == m_rep, req, int'(repair), int'(m_rep));
    check(int'(cnt) == m_cnt, req, int'(cnt), m_cnt);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        finish_up();
      end
    end
  end

  initial begin
    int r;
    int b;
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    check(repair == 0, "R1", int'(repair), 0);
    check(cnt == 0, "R1", int'(cnt), 0);
    rst_n = 1'b1;
    @(negedge clk);

    cyc(0, 1, 100, "R5");
    cyc(0, 1, 100, "R3");
    cyc(0, 1, 200, "R4 up");
    cyc(0, 1, 200, "R3");
    cyc(0, 1, 150, "R4 down");
    cyc(0, 1, 150, "R3");
    cyc(0, 0, 0, "R10");
    cyc(0, 0, 0, "R10");
    cyc(0, 1, 150, "R3");
    cyc(0, 1, 150, "R6");
    check(repair == 1, "R6 limit 3", int'(repair), 1);
    cyc(0, 1, 999, "R7");
    cyc(0, 1, 10, "R7");
    cyc(1, 0, 0, "R8");
    cyc(0, 1, 150, "R8 prev cleared R5");

    cyc(0, 1, 949, "R2 below");
    check(repair == 0, "R2 949", int'(repair), 0);
    cyc(0, 1, 950, "R2 boundary");
    check(repair == 1, "R2 950", int'(repair), 1);
    cyc(1, 1, 150, "R8 priority");

    limit = 0;
    cyc(0, 1, 77, "R6 limit 0");
    check(repair == 1, "R6 limit 0", int'(repair), 1);
    cyc(1, 0, 0, "R8");

    limit = 9'd300;
    cyc(0, 1, 500, "R5");
    for (int i = 0; i < 299; i++) cyc(0, 1, 500, "R3 run");
    check(repair == 0 && cnt == 299, "R6 299", int'(cnt), 299);
    cyc(0, 1, 500, "R6 300");
    check(repair == 1, "R6 300", int'(repair), 1);
    cyc(1, 0, 0, "R8");

    limit = 9'd4;
    for (int i = 0; i < 2000; i++) begin
      if (m_rep) begin
        r = int'($urandom % 3);
        if (r == 0) cyc(1, 0, 0, "R8 rand");
        else cyc(0, 1, int'($urandom % 1000), "R7 rand");
      end else begin
        r = int'($urandom % 5);
        case (r)
          0, 1: b = m_hp ? m_prev : 300;
          2: b = int'($urandom % 950);
          3: b = 950 + int'($urandom % 51);
          default: b = m_prev + 1;
        endcase
        if (($urandom % 8) == 0) cyc(0, 0, b, "R10 rand");
        else cyc(0, 1, b, "R3 R4 rand");
      end
    end

    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      s_valid = 1; s_best = 16'd40;
      @(negedge clk);
      s_valid = 0;
    end
    check(s_cnt == 3'd7, "R9 saturate", int'(s_cnt), 7);
    check(s_repair == 0, "R9 no trigger", int'(s_repair), 0);

    finish_up();
  end
endmodule